// File: doc/BRIEF.md
# Two-Digit BCD Up/Down Seconds Timer

This block is a decimal seconds timer built around two BCD digits, each shown on its own seven-segment display. An operator holds a load button and sets each digit with four switch inputs. While the button is down, both displays follow the switches at once, and the count direction is taken from a direction input. Releasing the button starts the timer. The timer then moves one step per second, up or down, and halts at its end value instead of wrapping.

The one-second step comes from a counter that divides the system clock by `TICK_DIV`. The default of 50,000,000 suits a 50 MHz clock. The divider output is a single-cycle enable inside the one clock domain. It is never used as a clock. A set/reset run flag decides whether the divider and the digits advance. Release sets the flag, and the step that lands on the end value clears it. Two status outputs show the direction in effect and whether the timer is running. The digit count `NDIG` is a parameter; the default is two.

Top module: `bcd_updown_timer`

## Requirements
- R1: A synchronous active-high `rst` sets both digits to 0, clears the run flag and selects the up direction (`dir_up_led` = 1 when `load_btn` is low).
- R2: While `load_btn` is high, `seg_n` shows the switch digits in the same cycle, `running_led` is 0 from the next clock on, and no counting takes place however long the button is held.
- R3: A switch nibble above 9 is loaded, and shown, as 9.
- R4: The first clock edge that samples `load_btn` low after it was high starts the run. The first step happens exactly `TICK_DIV` clock edges after that edge, and later steps follow every `TICK_DIV` edges.
- R5: Counting up, the ones digit goes from 9 to 0 and carries +1 into the tens digit.
- R6: Counting down, the ones digit goes from 0 to 9 and borrows 1 from the tens digit.
- R7: Counting up stops at 99, and counting down stops at 00. The step that reaches the end value drops `running_led`. A release while the loaded value already equals the end value leaves the timer stopped.
- R8: `seg_n[6:0]` drives the ones display and `seg_n[13:7]` the tens display. Segments are active-low, with a..g on bits 0..6. The lit segments for each digit are: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 all, 9 abcdfg.
- R9: `dir_up_led` is 1 for up and 0 for down. While `load_btn` is high it follows `dir_up_in`. After release it holds the value captured during load, and changes to `dir_up_in` have no effect.
- R10: Every stored digit is always a valid BCD value (0..9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_btn | input | 1 | Load button: high = set from switches, falling = start |
| dir_up_in | input | 1 | Direction select, 1 = count up |
| sw_bcd | input | NDIG*4 | Switch digits, ones in bits 3:0 |
| seg_n | output | NDIG*7 | Active-low segments, ones display in bits 6:0 |
| dir_up_led | output | 1 | Direction status, 1 = up |
| running_led | output | 1 | 1 while the timer is counting |

## Verification
The embedded properties check the following on every cycle:
- every digit stays in 0..9;
- the run flag is never set while the count sits at its end value;
- each divider tick moves the whole count by exactly one decimal step in the latched direction;
- ticks never come back to back;
- the run flag only rises just after a button release.

Other behaviour is only visible in the bench's scenarios:
- the exact second-boundary timing after release;
- clamping of out-of-range switch nibbles;
- the live display during load;
- the segment patterns themselves;
- the direction input having no effect during a run.

// File: rtl/bcd_timer_pkg.sv
package bcd_timer_pkg;

  // Limit a switch nibble to a legal decimal digit.
  function automatic logic [3:0] clamp_bcd(input logic [3:0] d);
    return (d > 4'd9) ? 4'd9 : d;
  endfunction

  // Lit segments (active high), bit 0 = a ... bit 6 = g.
  function automatic logic [6:0] seg_lit(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0: s = 7'b0111111;
      4'd1: s = 7'b0000110;
      4'd2: s = 7'b1011011;
      4'd3: s = 7'b1001111;
      4'd4: s = 7'b1100110;
      4'd5: s = 7'b1101101;
      4'd6: s = 7'b1111101;
      4'd7: s = 7'b0000111;
      4'd8: s = 7'b1111111;
      4'd9: s = 7'b1101111;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction

  // One decimal digit step; returns the new digit.
  function automatic logic [3:0] digit_step(input logic [3:0] d, input logic up);
    logic [3:0] r;
    if (up) r = (d == 4'd9) ? 4'd0 : 4'(d + 4'd1);
    else    r = (d == 4'd0) ? 4'd9 : 4'(d - 4'd1);
    return r;
  endfunction

endpackage

// File: rtl/bcd_timer_tick.sv
module bcd_timer_tick #(
  parameter int unsigned TICK_DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic enable,
  output logic tick
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !enable) cnt_q <= '0;
    else if (cnt_q == LAST)        cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  assign tick = enable && (cnt_q == LAST);

  generate
    if (TICK_DIV > 1) begin : g_gap_chk
      // R4
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
      // R4
      restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/bcd_timer_digit.sv
module bcd_timer_digit
  import bcd_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [3:0] load_val,
  input  logic       step,
  input  logic       up,
  output logic [3:0] val,
  output logic       is_nine,
  output logic       is_zero
);
  always_ff @(posedge clk) begin
    if (rst)       val <= 4'd0;
    else if (load) val <= clamp_bcd(load_val);
    else if (step) val <= digit_step(val, up);
  end

  assign is_nine = (val == 4'd9);
  assign is_zero = (val == 4'd0);

  // R10
  digit_bcd_chk: assert property (@(posedge clk) disable iff (rst)
    val <= 4'd9);
  // R5
  digit_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (step && up && !load && val == 4'd9) |=> val == 4'd0);
  // R6
  digit_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !up && !load && val == 4'd0) |=> val == 4'd9);

endmodule

// File: rtl/bcd_timer_segdec.sv
module bcd_timer_segdec
  import bcd_timer_pkg::*;
(
  input  logic [3:0] digit,
  output logic [6:0] seg_n
);
  assign seg_n = ~seg_lit(digit);
endmodule

// File: rtl/bcd_updown_timer.sv
module bcd_updown_timer
  import bcd_timer_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50_000_000,
  parameter int unsigned NDIG     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_btn,
  input  logic              dir_up_in,
  input  logic [NDIG*4-1:0] sw_bcd,
  output logic [NDIG*7-1:0] seg_n,
  output logic              dir_up_led,
  output logic              running_led
);
  localparam int unsigned VW = NDIG * 4;

  logic          load_q;
  logic          dir_q;
  logic          run_q;
  logic          release_evt;
  logic          tick;
  logic          at_term;
  logic          term_next;
  logic [VW-1:0] cur;
  logic [NDIG-1:0] nine, zero, step;

  // Whole-count decimal step, used only to check the chained digits.
  function automatic logic [VW-1:0] bcd_next(input logic [VW-1:0] v, input logic up);
    logic [VW-1:0] r;
    logic          c;
    r = v;
    c = 1'b1;
    for (int i = 0; i < NDIG; i++) begin
      if (c) begin
        r[i*4 +: 4] = digit_step(v[i*4 +: 4], up);
        c = up ? (v[i*4 +: 4] == 4'd9) : (v[i*4 +: 4] == 4'd0);
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) load_q <= 1'b0;
    else     load_q <= load_btn;
  end

  assign release_evt = load_q && !load_btn;

  always_ff @(posedge clk) begin
    if (rst)           dir_q <= 1'b1;
    else if (load_btn) dir_q <= dir_up_in;
  end

  bcd_timer_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (release_evt),
    .enable  (run_q),
    .tick    (tick)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NDIG; gi++) begin : g_dig
      logic [3:0] shown;
      if (gi == 0) begin : g_lsd
        assign step[gi] = tick;
      end else begin : g_chain
        assign step[gi] = step[gi-1] && (dir_q ? nine[gi-1] : zero[gi-1]);
      end

      bcd_timer_digit u_digit (
        .clk      (clk),
        .rst      (rst),
        .load     (load_btn),
        .load_val (sw_bcd[gi*4 +: 4]),
        .step     (step[gi]),
        .up       (dir_q),
        .val      (cur[gi*4 +: 4]),
        .is_nine  (nine[gi]),
        .is_zero  (zero[gi])
      );

      assign shown = load_btn ? clamp_bcd(sw_bcd[gi*4 +: 4]) : cur[gi*4 +: 4];

      bcd_timer_segdec u_seg (
        .digit (shown),
        .seg_n (seg_n[gi*7 +: 7])
      );
    end
  endgenerate

  // End value reached now, and end value reached by the next step.
  assign at_term = dir_q ? (&nine) : (&zero);

  generate
    if (NDIG > 1) begin : g_tn_multi
      assign term_next = dir_q ? ((&nine[NDIG-1:1]) && cur[3:0] == 4'd8)
                               : ((&zero[NDIG-1:1]) && cur[3:0] == 4'd1);
    end else begin : g_tn_single
      assign term_next = dir_q ? (cur[3:0] == 4'd8) : (cur[3:0] == 4'd1);
    end
  endgenerate

  // Set/reset run flag: set on release, cleared on landing at the end value.
  always_ff @(posedge clk) begin
    if (rst)                    run_q <= 1'b0;
    else if (load_btn)          run_q <= 1'b0;
    else if (release_evt)       run_q <= !at_term;
    else if (tick && term_next) run_q <= 1'b0;
  end

  assign dir_up_led  = load_btn ? dir_up_in : dir_q;
  assign running_led = run_q;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cur == '0 && dir_q && !run_q));
  // R2
  load_halts_chk: assert property (@(posedge clk) disable iff (rst)
    load_btn |=> !run_q);
  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !(run_q && at_term));
  // R5
  step_size_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load_btn) |=> cur == $past(bcd_next(cur, dir_q)));
  // R4
  run_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> $past(release_evt));
  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_btn |=> $stable(dir_q));

endmodule

// File: tb/bcd_updown_timer_tb.sv
`timescale 1ns/100ps
module bcd_updown_timer_tb;
  localparam int DIV = 4;
  localparam int NV  = 10;

  // {dir_up, sw_tens, sw_ones, ticks[7:0], exp_tens, exp_ones, exp_run}
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 4'd0,  4'd0,  8'd3,  4'd0, 4'd3, 1'b1},
    {1'b1, 4'd0,  4'd9,  8'd1,  4'd1, 4'd0, 1'b1},
    {1'b1, 4'd9,  4'd7,  8'd5,  4'd9, 4'd9, 1'b0},
    {1'b0, 4'd1,  4'd0,  8'd1,  4'd0, 4'd9, 1'b1},
    {1'b0, 4'd0,  4'd2,  8'd4,  4'd0, 4'd0, 1'b0},
    {1'b0, 4'd5,  4'd0,  8'd11, 4'd3, 4'd9, 1'b1},
    {1'b1, 4'd12, 4'd15, 8'd0,  4'd9, 4'd9, 1'b0},
    {1'b0, 4'd15, 4'd3,  8'd2,  4'd9, 4'd1, 1'b1},
    {1'b0, 4'd0,  4'd0,  8'd2,  4'd0, 4'd0, 1'b0},
    {1'b1, 4'd1,  4'd9,  8'd12, 4'd3, 4'd1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_btn = 1'b0;
  logic        dir_up_in = 1'b1;
  logic [7:0]  sw_bcd = 8'h00;
  logic [13:0] seg_n;
  logic        dir_up_led;
  logic        running_led;

  int applied = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  bcd_updown_timer #(.TICK_DIV(DIV), .NDIG(2)) u_dut (
    .clk(clk), .rst(rst), .load_btn(load_btn), .dir_up_in(dir_up_in),
    .sw_bcd(sw_bcd), .seg_n(seg_n), .dir_up_led(dir_up_led),
    .running_led(running_led)
  );

  // Active-low patterns from R8 (bit 0 = a).
  function automatic logic [6:0] exp_seg(input int d);
    case (d)
      0: return 7'h40;  1: return 7'h79;  2: return 7'h24;  3: return 7'h30;
      4: return 7'h19;  5: return 7'h12;  6: return 7'h02;  7: return 7'h78;
      8: return 7'h00;  default: return 7'h10;
    endcase
  endfunction

  function automatic int lim9(input int d);
    return (d > 9) ? 9 : d;
  endfunction

  task automatic chk_disp(input string req, input int t, input int o);
    logic [13:0] e;
    e = {exp_seg(t), exp_seg(o)};
    applied++;
    if (seg_n !== e) begin
      errors++;
      $display("FAIL %s seg_n actual=%h expected=%h (%0d%0d)", req, seg_n, e, t, o);
    end
  endtask

  task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
    applied++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Hold load with the given settings for a few clocks (drives at negedge).
  task automatic do_load(input logic up, input int t, input int o);
    @(negedge clk);
    load_btn  = 1'b1;
    dir_up_in = up;
    sw_bcd    = {4'(t), 4'(o)};
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk_disp("R1", 0, 0);
    chk_bit("R1", "running_led", running_led, 1'b0);
    chk_bit("R1", "dir_up_led", dir_up_led, 1'b1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic up; int st, so, tk, et, eo; logic er;
      up = VEC[v][25]; st = VEC[v][24:21]; so = VEC[v][20:17];
      tk = VEC[v][16:9]; et = VEC[v][8:5]; eo = VEC[v][4:1]; er = VEC[v][0];
      do_load(up, st, so);
      // R2 R3 R8 R9: live display of clamped switches while loading
      chk_disp("R2 R3 R8", lim9(st), lim9(so));
      chk_bit("R2", "running_led during load", running_led, 1'b0);
      chk_bit("R9", "dir_up_led during load", dir_up_led, up);
      load_btn = 1'b0;
      dir_up_in = ~up; // R9: ignored after release
      repeat (1 + tk * DIV) @(negedge clk);
      // R5 R6 R7 R10: count after tk seconds
      chk_disp("R5 R6 R7 R10", et, eo);
      chk_bit("R7", "running_led", running_led, er);
      chk_bit("R9", "dir_up_led after release", dir_up_led, up);
    end

    // R4: first step exactly DIV edges after the release edge
    do_load(1'b1, 0, 5);
    load_btn = 1'b0;
    repeat (DIV) @(negedge clk);          // release edge + DIV-1 edges
    chk_disp("R4 before first step", 0, 5);
    chk_bit("R4", "running_led", running_led, 1'b1);
    @(negedge clk);
    chk_disp("R4 first step", 0, 6);
    repeat (DIV - 1) @(negedge clk);
    chk_disp("R4 second not early", 0, 6);
    @(negedge clk);
    chk_disp("R4 second step", 0, 7);

    // R2: pressing load mid-run follows switches at once and stops counting
    @(negedge clk);
    load_btn = 1'b1; dir_up_in = 1'b0; sw_bcd = 8'h42;
    #1;
    chk_disp("R2 mid-run reload", 4, 2);
    repeat (5 * DIV) @(negedge clk);
    chk_disp("R2 held load no count", 4, 2);
    chk_bit("R2", "running_led held", running_led, 1'b0);

    // R1: reset during a run
    load_btn = 1'b0;
    repeat (2 * DIV + 1) @(negedge clk);
    chk_disp("R6 running before reset", 4, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_disp("R1 reset mid-run", 0, 0);
    chk_bit("R1", "running_led", running_led, 1'b0);
    chk_bit("R1", "dir_up_led", dir_up_led, 1'b1);
    repeat (3 * DIV) @(negedge clk);
    chk_disp("R1 stays idle", 0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

endmodule